// File: doc/BRIEF.md
# Condition Code Register Unit

This block holds the flag register of a small 8-bit accumulator processor. The datapath gives it the ALU result, the carry out of bit 7 and the carry out of bit 3 each cycle. It also gives it a code that names the operation class. From these it updates the half-carry, negative, zero and carry flags. It updates only the flags that belong to the class and leaves every other flag as it was.

Control strobes act on the interrupt mask and the carry flag directly. Other strobes reload the whole register from a data bus, as happens when a saved copy is restored on return from interrupt or on a pop. The three upper bits are wired to 1. An interrupt request that arrives while the mask is set is held. It is signalled on the pending output once the mask is clear.

Top module: `ccr_unit`

## Requirements
- R1: After reset the register reads E8h (bits 7:5 = 1, mask bit 3 = 1, H/N/Z/C = 0) and `irq_pending` is 0.
- R2: Bits 7:5 of `ccr` read 1 in every cycle, also after a load of 00h from the bus.
- R3: Flag positions are H = bit 4, I = bit 3, N = bit 2, Z = bit 1, C = bit 0. With `op_class` = 1 (add), H takes `half_carry`, C takes `carry_out`, N takes `result[7]` and Z is 1 exactly when `result` is 0, one cycle later.
- R4: With any `op_class` other than 1, H keeps its value.
- R5: With `op_class` = 3 (logic/move), N and Z update from `result`, while C and H keep their values.
- R6: With `op_class` = 2 (subtract/compare) or 4 (shift/rotate), N, Z and C update, while H keeps its value.
- R7: With `op_class` = 5 (bit test), only C updates (from `carry_out`); N, Z and H keep their values.
- R8: With `op_class` = 0, 6 or 7 and no strobe, the whole register keeps its value.
- R9: `set_carry` forces C to 1 and `clr_carry` forces C to 0, both over the operation class. If both are high, set wins.
- R10: `set_mask` or `irq_enter` sets I. `clr_mask` clears I. If a set and a clear arrive together, the set wins.
- R11: `pop_load` or `irq_return` loads bits 4:0 from `bus_in[4:0]`. This load overrides every other strobe and the operation class in that cycle.
- R12: A pulse on `irq_req` is held until `irq_enter`. `irq_pending` is 1 from the next cycle on whenever a request is held and I is 0. A request that arrives in the same cycle as `irq_enter` is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_class | input | 3 | Operation class: 0 none, 1 add, 2 subtract/compare, 3 logic/move, 4 shift/rotate, 5 bit test |
| result | input | 8 | ALU result |
| carry_out | input | 1 | Carry or borrow out of the operation |
| half_carry | input | 1 | Carry from bit 3 into bit 4 |
| set_carry | input | 1 | Force C to 1 |
| clr_carry | input | 1 | Force C to 0 |
| set_mask | input | 1 | Set interrupt mask |
| clr_mask | input | 1 | Clear interrupt mask |
| irq_enter | input | 1 | Interrupt entry: set mask, consume held request |
| irq_return | input | 1 | Return from interrupt: reload flags from bus |
| pop_load | input | 1 | Pop: reload flags from bus |
| bus_in | input | 8 | Data bus value for reloads |
| irq_req | input | 1 | Interrupt request pulse |
| ccr | output | 8 | Register value |
| irq_pending | output | 1 | Held request while unmasked |

## Verification
The assertions check on every cycle the rules that hold under any stimulus. Interrupt entry leaves the mask set. H stays unchanged outside the add class. N and Z stay unchanged for classes that do not own them. The carry strobes win over the class. A held request stays held until entry. The priority between a reload and the other strobes cannot be shown by these properties. Nor can the exact result-derived values, or the timing of pending release after a mask clear. The bench scenarios and the per-cycle reference model show those.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned FLAG_W = 5;
  localparam int unsigned BIT_H = 4;
  localparam int unsigned BIT_I = 3;
  localparam int unsigned BIT_N = 2;
  localparam int unsigned BIT_Z = 1;
  localparam int unsigned BIT_C = 0;

  typedef enum logic [2:0] {
    OPC_NONE  = 3'd0,
    OPC_ADD   = 3'd1,
    OPC_ARITH = 3'd2,
    OPC_LOGIC = 3'd3,
    OPC_SHIFT = 3'd4,
    OPC_BTEST = 3'd5
  } op_class_e;

  typedef struct packed {
    logic upd_h;
    logic upd_nz;
    logic upd_c;
  } upd_mask_t;

  function automatic upd_mask_t class_mask(logic [2:0] oc);
    upd_mask_t m;
    m = '0;
    unique case (oc)
      OPC_ADD:   m = '{upd_h: 1'b1, upd_nz: 1'b1, upd_c: 1'b1};
      OPC_ARITH: m = '{upd_h: 1'b0, upd_nz: 1'b1, upd_c: 1'b1};
      OPC_SHIFT: m = '{upd_h: 1'b0, upd_nz: 1'b1, upd_c: 1'b1};
      OPC_LOGIC: m = '{upd_h: 1'b0, upd_nz: 1'b1, upd_c: 1'b0};
      OPC_BTEST: m = '{upd_h: 1'b0, upd_nz: 1'b0, upd_c: 1'b1};
      default:   m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/ccr_flag_next.sv
module ccr_flag_next
  import ccr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [FLAG_W-1:0] flags_q,
  input  logic [2:0]        op_class,
  input  logic [W-1:0]      result,
  input  logic              carry_out,
  input  logic              half_carry,
  input  logic              set_carry,
  input  logic              clr_carry,
  input  logic              set_mask,
  input  logic              clr_mask,
  input  logic              irq_enter,
  input  logic              reload,
  input  logic [FLAG_W-1:0] reload_val,
  output logic [FLAG_W-1:0] flags_d,
  output logic              flags_en
);
  localparam int unsigned MSB = W - 1;

  upd_mask_t um;
  logic      res_zero;

  always_comb begin
    um       = class_mask(op_class);
    res_zero = (result == '0);
    flags_d  = flags_q;
    if (reload) begin
      flags_d = reload_val;
    end else begin
      if (um.upd_h)  flags_d[BIT_H] = half_carry;
      if (um.upd_nz) begin
        flags_d[BIT_N] = result[MSB];
        flags_d[BIT_Z] = res_zero;
      end
      if (set_carry)      flags_d[BIT_C] = 1'b1;
      else if (clr_carry) flags_d[BIT_C] = 1'b0;
      else if (um.upd_c)  flags_d[BIT_C] = carry_out;
      if (set_mask || irq_enter) flags_d[BIT_I] = 1'b1;
      else if (clr_mask)         flags_d[BIT_I] = 1'b0;
    end
    flags_en = reload || um.upd_h || um.upd_nz || um.upd_c || set_carry ||
               clr_carry || set_mask || clr_mask || irq_enter;
  end
endmodule

// File: rtl/ccr_irq_hold.sv
module ccr_irq_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic irq_enter,
  input  logic mask_q,
  output logic irq_pending
);
  logic held_q;
  logic held_d;
  logic held_en;

  always_comb begin
    held_d  = (held_q && !irq_enter) || irq_req;
    held_en = irq_req || irq_enter;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= 1'b0;
    else if (held_en) held_q <= held_d;
  end

  assign irq_pending = held_q && !mask_q;

  assert_held_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !irq_enter) |=> held_q);
  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> held_q);
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op_class,
  input  logic [W-1:0] result,
  input  logic         carry_out,
  input  logic         half_carry,
  input  logic         set_carry,
  input  logic         clr_carry,
  input  logic         set_mask,
  input  logic         clr_mask,
  input  logic         irq_enter,
  input  logic         irq_return,
  input  logic         pop_load,
  input  logic [W-1:0] bus_in,
  input  logic         irq_req,
  output logic [W-1:0] ccr,
  output logic         irq_pending
);
  localparam int unsigned FIXED_W = W - FLAG_W;
  localparam logic [FLAG_W-1:0] FLAGS_RST = FLAG_W'(1) << BIT_I;

  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] flags_d;
  logic              flags_en;
  logic              reload;

  assign reload = pop_load || irq_return;

  ccr_flag_next #(.W(W)) u_next (
    .flags_q    (flags_q),
    .op_class   (op_class),
    .result     (result),
    .carry_out  (carry_out),
    .half_carry (half_carry),
    .set_carry  (set_carry),
    .clr_carry  (clr_carry),
    .set_mask   (set_mask),
    .clr_mask   (clr_mask),
    .irq_enter  (irq_enter),
    .reload     (reload),
    .reload_val (bus_in[FLAG_W-1:0]),
    .flags_d    (flags_d),
    .flags_en   (flags_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= FLAGS_RST;
    else if (flags_en) flags_q <= flags_d;
  end

  ccr_irq_hold u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .irq_enter   (irq_enter),
    .mask_q      (flags_q[BIT_I]),
    .irq_pending (irq_pending)
  );

  assign ccr = {{FIXED_W{1'b1}}, flags_q};

  assert_enter_masks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && !reload) |=> ccr[BIT_I]);
  assert_h_only_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class != OPC_ADD && !reload) |=> $stable(ccr[BIT_H]));
  assert_nz_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == OPC_BTEST && !reload) |=> $stable(ccr[BIT_N:BIT_Z]));
  assert_set_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_carry && !reload) |=> ccr[BIT_C]);
  assert_clr_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_carry && !set_carry && !reload) |=> !ccr[BIT_C]);
  assert_logic_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == OPC_LOGIC && !reload && result == '0) |=> ccr[BIT_Z]);
endmodule

// File: tb/ccr_unit_tb.sv
module ccr_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [2:0] op_class;
  logic [7:0] result;
  logic       carry_out, half_carry, set_carry, clr_carry;
  logic       set_mask, clr_mask, irq_enter, irq_return, pop_load, irq_req;
  logic [7:0] bus_in;
  logic [7:0] ccr;
  logic       irq_pending;

  int checks = 0;
  int errors = 0;

  // reference state
  bit m_h, m_i, m_n, m_z, m_c, m_held;

  ccr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_class(op_class), .result(result),
    .carry_out(carry_out), .half_carry(half_carry), .set_carry(set_carry),
    .clr_carry(clr_carry), .set_mask(set_mask), .clr_mask(clr_mask),
    .irq_enter(irq_enter), .irq_return(irq_return), .pop_load(pop_load),
    .bus_in(bus_in), .irq_req(irq_req), .ccr(ccr), .irq_pending(irq_pending)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic idle();
    op_class = 3'd0; result = 8'h00; carry_out = 0; half_carry = 0;
    set_carry = 0; clr_carry = 0; set_mask = 0; clr_mask = 0;
    irq_enter = 0; irq_return = 0; pop_load = 0; bus_in = 8'h00; irq_req = 0;
  endtask

  function automatic logic [7:0] model_ccr();
    return {3'b111, m_h, m_i, m_n, m_z, m_c};
  endfunction

  task automatic model_step();
    bit ld;
    int oc;
    ld = pop_load || irq_return;
    oc = op_class;
    if (ld) begin
      m_h = bus_in[4]; m_i = bus_in[3]; m_n = bus_in[2];
      m_z = bus_in[1]; m_c = bus_in[0];
    end else begin
      if (oc == 1) m_h = half_carry;
      if (oc >= 1 && oc <= 4) begin
        m_n = result[7];
        m_z = (result == 8'h00);
      end
      if (set_carry) m_c = 1;
      else if (clr_carry) m_c = 0;
      else if (oc == 1 || oc == 2 || oc == 4 || oc == 5) m_c = carry_out;
      if (set_mask || irq_enter) m_i = 1;
      else if (clr_mask) m_i = 0;
    end
    if (irq_enter) m_held = 0;
    if (irq_req) m_held = 1;
  endtask

  task automatic compare(string tag);
    checks++;
    if (ccr !== model_ccr()) begin
      errors++;
      $display("FAIL %s: ccr got %h expected %h", tag, ccr, model_ccr());
    end
    checks++;
    if (irq_pending !== (m_held && !m_i)) begin
      errors++;
      $display("FAIL %s: irq_pending got %b expected %b", tag, irq_pending,
               m_held && !m_i);
    end
  endtask

  // inputs are set at a negedge; apply one clock and compare at the next negedge
  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
    idle();
  endtask

  task automatic expect_bits(string tag, logic [7:0] exp);
    checks++;
    if (ccr !== exp) begin
      errors++;
      $display("FAIL %s: ccr got %h expected %h", tag, ccr, exp);
    end
  endtask

  initial begin
    idle();
    rst_n = 0;
    m_h = 0; m_i = 1; m_n = 0; m_z = 0; m_c = 0; m_held = 0;
    repeat (3) @(negedge clk);
    expect_bits("R1 reset value", 8'hE8);
    compare("R1 reset");
    rst_n = 1;
    @(negedge clk);

    // R2: load zeros, top bits remain 1
    pop_load = 1; bus_in = 8'h00; cyc("R2");
    expect_bits("R2 fixed ones", 8'hE0);

    // R3: add with half carry, carry, negative result
    op_class = 3'd1; result = 8'h80; carry_out = 1; half_carry = 1; cyc("R3");
    expect_bits("R3 add flags", 8'hF5);
    op_class = 3'd1; result = 8'h00; carry_out = 0; half_carry = 0; cyc("R3");
    expect_bits("R3 add zero", 8'hE2);

    // R4: arith does not touch H
    op_class = 3'd1; result = 8'h01; half_carry = 1; cyc("R4");
    op_class = 3'd2; result = 8'h00; carry_out = 1; half_carry = 0; cyc("R4");
    expect_bits("R4 H kept by subtract", 8'hF3);

    // R5: logic keeps C and H
    op_class = 3'd3; result = 8'hFF; carry_out = 0; cyc("R5");
    expect_bits("R5 logic", 8'hF5);

    // R6: shift updates C
    op_class = 3'd4; result = 8'h40; carry_out = 0; cyc("R6");
    expect_bits("R6 shift", 8'hF0);

    // R7: bit test only C
    op_class = 3'd5; result = 8'h00; carry_out = 1; cyc("R7");
    expect_bits("R7 bit test", 8'hF1);

    // R8: none and unused codes hold
    op_class = 3'd0; result = 8'h00; carry_out = 0; half_carry = 0; cyc("R8");
    op_class = 3'd7; result = 8'h00; carry_out = 0; cyc("R8");
    expect_bits("R8 hold", 8'hF1);

    // R9: carry strobes over class, set wins
    op_class = 3'd2; carry_out = 1; clr_carry = 1; result = 8'h05; cyc("R9");
    expect_bits("R9 clear", 8'hF0);
    set_carry = 1; clr_carry = 1; cyc("R9");
    expect_bits("R9 set wins", 8'hF1);

    // R10: mask strobes
    clr_mask = 1; cyc("R10");
    expect_bits("R10 clear mask", 8'hF1 & ~8'h08);
    set_mask = 1; clr_mask = 1; cyc("R10");
    expect_bits("R10 set wins", 8'hF9);

    // R11: reload beats strobes and class
    irq_return = 1; bus_in = 8'h12; set_mask = 1; set_carry = 1;
    op_class = 3'd1; result = 8'h80; carry_out = 1; half_carry = 0; cyc("R11");
    expect_bits("R11 reload", 8'hF2);

    // R12: request while unmasked, then masked, then release
    irq_req = 1; cyc("R12");
    checks++;
    if (irq_pending !== 1'b1) begin
      errors++; $display("FAIL R12 unmasked pending: got %b expected 1", irq_pending);
    end
    irq_enter = 1; cyc("R12");
    set_mask = 1; cyc("R12");
    irq_req = 1; cyc("R12");
    checks++;
    if (irq_pending !== 1'b0) begin
      errors++; $display("FAIL R12 masked hold: got %b expected 0", irq_pending);
    end
    cyc("R12");
    clr_mask = 1; cyc("R12");
    checks++;
    if (irq_pending !== 1'b1) begin
      errors++; $display("FAIL R12 release: got %b expected 1", irq_pending);
    end
    irq_enter = 1; irq_req = 1; cyc("R12 same-cycle request");

    // mixed stimulus against the model
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom;
      op_class   = 3'($urandom_range(0, 7));
      result     = 8'($urandom);
      carry_out  = r[0];
      half_carry = r[1];
      set_carry  = (r[6:2] == 0);
      clr_carry  = (r[11:7] == 0);
      set_mask   = (r[15:12] == 0);
      clr_mask   = (r[19:16] < 3);
      irq_enter  = (r[23:20] == 0);
      irq_return = (r[27:24] == 0);
      pop_load   = (r[31:28] == 0);
      bus_in     = 8'($urandom);
      irq_req    = ($urandom_range(0, 7) == 0);
      cyc("model");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule